// File: doc/BRIEF.md
# Modulo-60 Two-Digit Cascaded Counter

This block counts enabled clock cycles from 00 to 59 and then wraps. It has two digit stages. The low stage is a decade digit that runs 0 to 9. The high stage is a modulo-6 digit, and it advances only when the low stage is at its last value and the count enable is high. Both digits are held in binary-coded form, so they can feed a display path or be compared directly. The block suits seconds or minutes timekeeping.

The block can also work as a 60:1 divider. When the count enable is high at 59, a terminal-count output goes high for that single cycle. This output can drive the enable of a further stage in a chain. For example, an enable that pulses at 60 Hz produces a terminal pulse at 1 Hz. The high stage clears when its next value would reach its modulus. That clear is synchronous, on the same edge as the low-stage wrap, so the outputs never pass through an out-of-range value.

Top module: `sixty_divider`

## Requirements
- R1: When `srst` is high at a rising clock edge, both digits become 0, whatever `count_en` is. `tc_out` is low while `srst` is high.
- R2: When `count_en` is low and `srst` is low, both digits keep their values across the edge and `tc_out` is low.
- R3: On an edge where `count_en` is high, the units digit advances by one. If it was 9, it returns to 0.
- R4: The tens digit advances by one only on an enabled edge where the units digit is 9. On all other edges it keeps its value.
- R5: From a count of 59, an enabled edge gives 00. The tens digit goes from 5 to 0 on the same edge where the units digit goes from 9 to 0.
- R6: `tc_out` is a combinational output. It is high exactly when `count_en` is high, `srst` is low, the units digit is 9 and the tens digit is 5.
- R7: The units digit never exceeds 9 and the tens digit never exceeds 5.
- R8: Over any run of 600 consecutive enabled edges that starts from 00, `tc_out` goes high on exactly 10 of them. This holds however many idle cycles lie between the enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Count enable; a high level advances the count on the edge |
| units_digit | output | 4 | Low digit, binary-coded 0 to 9 |
| tens_digit | output | 3 | High digit, binary-coded 0 to 5 |
| tc_out | output | 1 | Terminal count: high at 59 with the enable high |

## Verification
The corner that is hardest to reach from the ports is the count of 59 combined with the control inputs that compete there. These cases are: the enable dropping exactly at 59, reset arriving at 59 while the enable is high, and the double wrap itself. Reaching any of them takes 59 enabled edges, and a sparse random enable pattern rarely lines them up. For that reason, the bench drives directed runs up to 59 and then applies each competing input. Long random stretches follow, with an enable probability of about 70 percent and rare resets. These stretches pass through the wrap many times under different idle gaps. A fixed-stride enable run then checks the 60:1 pulse count.

// File: rtl/sixty_div_pkg.sv
package sixty_div_pkg;

   // Detection style for a stage's last value.
   typedef enum logic {
      DECODE_FULL    = 1'b0,   // compare every bit of the value
      DECODE_PARTIAL = 1'b1    // look only at the bits that are set in the last value
   } decode_style_e;

   // Number of bits needed to hold the values 0 to modulus-1.
   function automatic int unsigned digit_width(input int unsigned modulus);
      int unsigned w;
      w = 1;
      while ((1 << w) < modulus) w++;
      return w;
   endfunction

endpackage

// File: rtl/mod_digit_stage.sv
module mod_digit_stage
   import sixty_div_pkg::*;
#(
   parameter int unsigned   MOD   = 10,
   parameter decode_style_e STYLE = DECODE_PARTIAL,
   parameter int unsigned   W     = digit_width(MOD)
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         step_in,
   output logic [W-1:0] value,
   output logic         carry_out
);

   localparam logic [W-1:0] LAST_VAL = W'(MOD - 1);
   localparam logic [W:0]   MOD_VAL  = (W + 1)'(MOD);

   // Elaboration-time parameter checks
   if (MOD < 2) begin : g_bad_mod
      $error("mod_digit_stage: MOD must be at least 2");
   end
   if (W < digit_width(MOD)) begin : g_bad_width
      $error("mod_digit_stage: W too narrow for MOD");
   end

   logic [W:0] next_raw;
   logic       clear_on_mod;
   logic       at_last;

   assign next_raw     = {1'b0, value} + 1'b1;
   // Synchronous clear when the next value would equal the modulus
   assign clear_on_mod = (next_raw == MOD_VAL);

   if (STYLE == DECODE_PARTIAL) begin : g_partial
      // Valid because counting up, the first value with all LAST bits set is LAST
      assign at_last = &(value | ~LAST_VAL);
   end else begin : g_full
      assign at_last = (value == LAST_VAL);
   end

   assign carry_out = step_in & at_last;

   always_ff @(posedge clk) begin
      if (srst) begin
         value <= '0;
      end else if (step_in) begin
         if (clear_on_mod) value <= '0;
         else              value <= next_raw[W-1:0];
      end
   end

endmodule

// File: rtl/sixty_divider.sv
module sixty_divider
   import sixty_div_pkg::*;
#(
   parameter int unsigned   UNITS_MOD = 10,
   parameter int unsigned   TENS_MOD  = 6,
   parameter decode_style_e DECODE    = DECODE_PARTIAL,
   parameter int unsigned   UNITS_W   = digit_width(UNITS_MOD),
   parameter int unsigned   TENS_W    = digit_width(TENS_MOD)
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              count_en,
   output logic [UNITS_W-1:0] units_digit,
   output logic [TENS_W-1:0]  tens_digit,
   output logic              tc_out
);

   if (UNITS_MOD < 2 || TENS_MOD < 2) begin : g_bad_params
      $error("sixty_divider: both moduli must be at least 2");
   end

   logic units_step;
   logic units_carry;
   logic tens_carry;

   // Reset has priority; gating the step also keeps the terminal flag low in reset
   assign units_step = count_en & ~srst;

   mod_digit_stage #(
      .MOD   (UNITS_MOD),
      .STYLE (DECODE),
      .W     (UNITS_W)
   ) u_units (
      .clk       (clk),
      .srst      (srst),
      .step_in   (units_step),
      .value     (units_digit),
      .carry_out (units_carry)
   );

   // The tens stage is enabled only by the units terminal count
   mod_digit_stage #(
      .MOD   (TENS_MOD),
      .STYLE (DECODE),
      .W     (TENS_W)
   ) u_tens (
      .clk       (clk),
      .srst      (srst),
      .step_in   (units_carry),
      .value     (tens_digit),
      .carry_out (tens_carry)
   );

   assign tc_out = tens_carry;

endmodule

// File: rtl/sixty_divider_chk.sv
module sixty_divider_chk #(
   parameter int unsigned UNITS_MOD = 10,
   parameter int unsigned TENS_MOD  = 6,
   parameter int unsigned UNITS_W   = 4,
   parameter int unsigned TENS_W    = 3
) (
   input logic               clk,
   input logic               srst,
   input logic               count_en,
   input logic [UNITS_W-1:0] units_digit,
   input logic [TENS_W-1:0]  tens_digit,
   input logic               tc_out
);

   localparam logic [UNITS_W-1:0] U_LAST = UNITS_W'(UNITS_MOD - 1);
   localparam logic [TENS_W-1:0]  T_LAST = TENS_W'(TENS_MOD - 1);

   logic seen_edge = 1'b0;
   always_ff @(posedge clk) seen_edge <= 1'b1;

   assert_reset_clears_R1: assert property (@(posedge clk)
      srst |=> (units_digit == '0 && tens_digit == '0));

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (!count_en) |=> ($stable(units_digit) && $stable(tens_digit)));

   assert_units_wrap_R3: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (count_en && units_digit == U_LAST) |=> (units_digit == '0));

   assert_tens_holds_R4: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (units_digit != U_LAST) |=> $stable(tens_digit));

   assert_double_wrap_R5: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (count_en && units_digit == U_LAST && tens_digit == T_LAST)
         |=> (units_digit == '0 && tens_digit == '0));

   assert_tc_only_at_end_R6: assert property (@(posedge clk) disable iff (!seen_edge)
      tc_out |-> (count_en && !srst && units_digit == U_LAST && tens_digit == T_LAST));

   assert_tc_present_R6: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (count_en && units_digit == U_LAST && tens_digit == T_LAST) |-> tc_out);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (srst || !seen_edge)
      (units_digit <= U_LAST && tens_digit <= T_LAST));

endmodule

bind sixty_divider sixty_divider_chk #(
   .UNITS_MOD (UNITS_MOD),
   .TENS_MOD  (TENS_MOD),
   .UNITS_W   (UNITS_W),
   .TENS_W    (TENS_W)
) u_chk (
   .clk         (clk),
   .srst        (srst),
   .count_en    (count_en),
   .units_digit (units_digit),
   .tens_digit  (tens_digit),
   .tc_out      (tc_out)
);

// File: tb/tb_sixty_divider.sv
`timescale 1ns/100ps
module tb_sixty_divider;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       count_en = 1'b0;
   logic [3:0] units_digit;
   logic [2:0] tens_digit;
   logic       tc_out;

   int compared = 0;
   int mismatched = 0;
   int model = 0;
   int tc_seen = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sixty_divider dut (
      .clk         (clk),
      .srst        (srst),
      .count_en    (count_en),
      .units_digit (units_digit),
      .tens_digit  (tens_digit),
      .tc_out      (tc_out)
   );

   function automatic int exp_units(input int c); return c % 10; endfunction
   function automatic int exp_tens (input int c); return c / 10; endfunction
   function automatic int next_count(input int c, input bit e, input bit r);
      if (r) return 0;
      if (e) return (c + 1) % 60;
      return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // One clock: drive at negedge, check tc, then check digits after the edge
   task automatic step(input bit e, input bit r);
      int prev;
      string tag;
      @(negedge clk);
      srst = r;
      count_en = e;
      #1;
      check(r ? "R1 tc" : (e ? "R6 tc" : "R2 tc"), int'(tc_out),
            int'(e && !r && model == 59));
      if (tc_out) tc_seen++;
      @(posedge clk);
      prev = model;
      model = next_count(model, e, r);
      #1;
      if (r)                   tag = "R1";
      else if (!e)             tag = "R2";
      else if (prev == 59)     tag = "R5";
      else if (prev % 10 == 9) tag = "R4";
      else                     tag = "R3";
      check({tag, " units"}, int'(units_digit), exp_units(model));
      check({tag, " tens"}, int'(tens_digit), exp_tens(model));
      check("R7 range", int'(units_digit <= 9 && tens_digit <= 5), 1);
   endtask

   task automatic run_to(input int target);
      while (model != target) step(1'b1, 1'b0);
   endtask

   initial begin
      void'($urandom(32'h0005_EED1));
      // R1: reset state
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      // R3/R4/R5: full directed pass through the double wrap
      run_to(59);
      step(1'b0, 1'b0);          // R2: enable low at 59, hold, tc low
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);          // R5: 59 -> 00 with tc high (R6)
      // R1: reset at 59 with enable high wins
      run_to(59);
      step(1'b1, 1'b1);
      // R1: reset mid-count
      run_to(37);
      step(1'b0, 1'b1);
      // R8: 600 enabled edges with a fixed idle stride, from 00
      tc_seen = 0;
      for (int i = 0; i < 600; i++) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
         step(1'b0, 1'b0);
      end
      check("R8 pulses", tc_seen, 10);
      // Random stretch
      for (int i = 0; i < 6000; i++) begin
         bit e, r;
         e = ($urandom % 10) < 7;
         r = ($urandom % 200) == 0;
         step(e, r);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule